// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers a set of single-cycle or level hardware event lines into a sticky status register. It masks that register with a per-event enable register and gates the combined result with one global enable bit, then drives a single level-sensitive interrupt line toward the processor. Software reaches the block through a plain 32-bit register port with a write strobe, a byte address and combinational read data.

Status bits stay set until software clears them. A write of 1 to a status bit flips it, so software reads the status word, handles the events and writes the same word back to clear exactly the bits it saw. A dedicated reset register accepts a key. Writing the key value clears every register in the controller and emits a one-cycle reset pulse, which the neighbouring bus engine uses to flush its FIFOs. Writing any other value to that register does nothing.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and `soft_rst_o` is 0.
- R2: An event line that is high in a cycle sets its status bit (byte offset 0x20) at the next clock edge. The bit order is: bit 0 arbitration lost, 1 transmit error or transfer done, 2 transmit empty, 3 receive at threshold, 4 bus idle, 5 addressed as target, 6 no longer addressed, 7 transmit half empty.
- R3: A write to 0x20 inverts each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R4: When an event and an inverting write hit the same status bit in one cycle, the bit ends up set.
- R5: The enable register at 0x28 stores write-data bits 7:0. Bits 31:8 read as 0.
- R6: The global enable at 0x1C stores only write-data bit 31. All other bits read as 0.
- R7: `irq_o` is registered. It is 1 in the cycle after one in which the global enable is 1 and (status AND enable) is non-zero, and 0 otherwise.
- R8: A write of 0x0000000A to 0x40 clears status, enable and global enable and drops `irq_o` at the next edge. `soft_rst_o` is then high for exactly one cycle. This clear wins over any event in the same cycle.
- R9: A write of any other value to 0x40 changes no register and raises neither `soft_rst_o` nor `irq_o`.
- R10: Reads of 0x40 and of any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT (8) | Event lines, one per status bit |
| reg_addr | input | ADDR_W (8) | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt request |
| soft_rst_o | output | 1 | One-cycle pulse after a key write |

## Verification
Random event bursts of about one-in-eight density run together with random writes to every mapped address and to unmapped addresses. This shows whether setting, inverting and masking stay independent bit by bit. A directed collision of an event with an inverting write on the same bit checks that setting takes priority. Writes to the reset register, both the key and near-miss values, separate the clearing path from ordinary writes. Toggling the global enable while a pending bit is held checks that the gate acts apart from the mask, with the one-cycle output lag.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int unsigned OFS_GIE  = 32'h1C;
  localparam int unsigned OFS_STAT = 32'h20;
  localparam int unsigned OFS_EN   = 32'h28;
  localparam int unsigned OFS_RST  = 32'h40;
  localparam int unsigned RST_KEY  = 32'h0000000A;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2,
    SEL_GIE  = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/irq_ctl_decode.sv
module irq_ctl_decode
  import irq_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              wr_stat,
  output logic              wr_en,
  output logic              wr_gie,
  output logic              wr_rst,
  output rd_sel_e           rd_sel
);
  logic hit_stat, hit_en, hit_gie, hit_rst;

  always_comb begin
    hit_stat = (addr == ADDR_W'(OFS_STAT));
    hit_en   = (addr == ADDR_W'(OFS_EN));
    hit_gie  = (addr == ADDR_W'(OFS_GIE));
    hit_rst  = (addr == ADDR_W'(OFS_RST));
    wr_stat  = we & hit_stat;
    wr_en    = we & hit_en;
    wr_gie   = we & hit_gie;
    wr_rst   = we & hit_rst;
    if (hit_stat)     rd_sel = SEL_STAT;
    else if (hit_en)  rd_sel = SEL_EN;
    else if (hit_gie) rd_sel = SEL_GIE;
    else              rd_sel = SEL_NONE;
  end
endmodule

// File: rtl/irq_ctl_status.sv
module irq_ctl_status #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_all,
  input  logic [NUM_EVT-1:0] evt,
  input  logic               wr,
  input  logic [NUM_EVT-1:0] tog,
  output logic [NUM_EVT-1:0] stat_q
);
  logic [NUM_EVT-1:0] stat_nxt;
  logic [NUM_EVT-1:0] stat_ld;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_comb begin
      stat_ld[i] = clr_all | evt[i] | (wr & tog[i]);
      if (clr_all)              stat_nxt[i] = 1'b0;
      else if (evt[i])          stat_nxt[i] = 1'b1;
      else if (wr && tog[i])    stat_nxt[i] = ~stat_q[i];
      else                      stat_nxt[i] = stat_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[i] <= 1'b0;
      else if (stat_ld[i]) stat_q[i] <= stat_nxt[i];
    end
  end

  // events are never lost unless a key clear happens in the same cycle
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> ((stat_q & $past(evt)) == $past(evt)));

  // an inverting write with no event flips exactly the written-one bits
  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr_all && evt == '0) |=> (stat_q == ($past(stat_q) ^ $past(tog))));
endmodule

// File: rtl/irq_ctl_rstgen.sv
module irq_ctl_rstgen
  import irq_ctl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  logic [DATA_W-1:0] wdata,
  output logic              clr_all,
  output logic              pulse_q
);
  logic pulse_nxt;

  always_comb begin
    clr_all   = wr_rst & (wdata == DATA_W'(RST_KEY));
    pulse_nxt = clr_all;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_nxt;
  end

  assert_nonkey_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rst && wdata != DATA_W'(RST_KEY)) |=> !pulse_q);
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o,
  output logic               soft_rst_o
);
  localparam int GIE_BIT = DATA_W - 1;
  localparam int PAD_W   = DATA_W - NUM_EVT;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic    wr_stat, wr_en, wr_gie, wr_rst;
  rd_sel_e rd_sel;
  logic    clr_all;
  logic [NUM_EVT-1:0] stat_q;

  irq_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (reg_addr),
    .we      (reg_we),
    .wr_stat (wr_stat),
    .wr_en   (wr_en),
    .wr_gie  (wr_gie),
    .wr_rst  (wr_rst),
    .rd_sel  (rd_sel)
  );

  irq_ctl_rstgen #(.DATA_W(DATA_W)) u_rst (
    .clk     (clk),
    .rst_n   (rst_s2),
    .wr_rst  (wr_rst),
    .wdata   (reg_wdata),
    .clr_all (clr_all),
    .pulse_q (soft_rst_o)
  );

  irq_ctl_status #(.NUM_EVT(NUM_EVT)) u_stat (
    .clk     (clk),
    .rst_n   (rst_s2),
    .clr_all (clr_all),
    .evt     (evt_i),
    .wr      (wr_stat),
    .tog     (reg_wdata[NUM_EVT-1:0]),
    .stat_q  (stat_q)
  );

  // enable mask and global gate
  logic [NUM_EVT-1:0] en_q, en_nxt;
  logic               en_ld;
  logic               gie_q, gie_nxt, gie_ld;
  logic               irq_q, irq_nxt;

  always_comb begin
    en_ld   = clr_all | wr_en;
    en_nxt  = clr_all ? '0 : reg_wdata[NUM_EVT-1:0];
    gie_ld  = clr_all | wr_gie;
    gie_nxt = clr_all ? 1'b0 : reg_wdata[GIE_BIT];
    irq_nxt = !clr_all && gie_q && |(stat_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      en_q  <= '0;
      gie_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (en_ld)  en_q  <= en_nxt;
      if (gie_ld) gie_q <= gie_nxt;
      irq_q <= irq_nxt;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_sel)
      SEL_STAT: reg_rdata = {{PAD_W{1'b0}}, stat_q};
      SEL_EN:   reg_rdata = {{PAD_W{1'b0}}, en_q};
      SEL_GIE:  reg_rdata = {gie_q, {(DATA_W-1){1'b0}}};
      default:  reg_rdata = '0;
    endcase
  end

  assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_s2)
    !gie_q |=> !irq_o);

  assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_s2)
    ((stat_q & en_q) == '0) |=> !irq_o);

  assert_key_clears_R8: assert property (@(posedge clk) disable iff (!rst_s2)
    soft_rst_o |-> (stat_q == '0 && en_q == '0 && !gie_q && !irq_o));
endmodule

// File: tb/test_irq_ctl_top.sv
`timescale 1ns/1ps
module test_irq_ctl_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic [7:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o, soft_rst_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_stat, m_en;
  logic       m_gie, m_irq, m_srst;

  always #4 clk = ~clk;

  irq_ctl_top i_irq_ctl_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .soft_rst_o(soft_rst_o)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h20:   return {24'd0, m_stat};
      8'h28:   return {24'd0, m_en};
      8'h1C:   return {m_gie, 31'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, model the edge, check at the next negedge
  task automatic cyc(input logic [7:0] ev, input logic we, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
    logic key;
    evt_i = ev; reg_we = we; reg_addr = a; reg_wdata = d;
    key = we && a == 8'h40 && d == 32'hA;
    if (key) begin
      m_stat = 0; m_en = 0; m_gie = 0; m_irq = 0; m_srst = 1;
    end else begin
      m_irq  = m_gie && ((m_stat & m_en) != 0);
      m_srst = 0;
      m_stat = (m_stat ^ ((we && a == 8'h20) ? d[7:0] : 8'h00)) | ev;
      if (we && a == 8'h28) m_en  = d[7:0];
      if (we && a == 8'h1C) m_gie = d[31];
    end
    @(posedge clk);
    @(negedge clk);
    evt_i = 0; reg_we = 0;
    chk(tag, "rdata", reg_rdata, exp_read(a));
    chk(tag, "irq_o", {31'd0, irq_o}, {31'd0, m_irq});
    chk(tag, "soft_rst_o", {31'd0, soft_rst_o}, {31'd0, m_srst});
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] addrs [6];
    addrs = '{8'h20, 8'h28, 8'h1C, 8'h40, 8'h00, 8'h24};
    void'($urandom(32'd20240611));
    evt_i = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    m_stat = 0; m_en = 0; m_gie = 0; m_irq = 0; m_srst = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset state of every register and output
    cyc(0, 0, 8'h20, 0, "R1"); cyc(0, 0, 8'h28, 0, "R1");
    cyc(0, 0, 8'h1C, 0, "R1"); cyc(0, 0, 8'h40, 0, "R1");

    // R2: each event line sets its own bit
    for (int i = 0; i < 8; i++) cyc(8'(1 << i), 0, 8'h20, 0, "R2");
    // R3: write back the read value clears; zeros leave bits
    cyc(0, 1, 8'h20, 32'h0F, "R3");
    cyc(0, 1, 8'h20, 32'h00, "R3");
    cyc(0, 1, 8'h20, 32'h30, "R3");
    // R4: event wins over an inverting write on the same bit
    cyc(8'h01, 1, 8'h20, 32'h01, "R4");
    cyc(8'h80, 1, 8'h20, 32'h81, "R4");
    // R5 / R6: enable and global enable storage
    cyc(0, 1, 8'h28, 32'hFFFF_FF01, "R5");
    cyc(0, 1, 8'h1C, 32'h7FFF_FFFF, "R6");
    cyc(0, 1, 8'h1C, 32'h8000_0000, "R6");
    // R7: output follows gate and mask one cycle later
    cyc(0, 0, 8'h20, 0, "R7");
    cyc(0, 1, 8'h1C, 32'h0, "R7");
    cyc(0, 0, 8'h1C, 0, "R7");
    cyc(0, 1, 8'h1C, 32'h8000_0000, "R7");
    cyc(0, 1, 8'h28, 32'h00, "R7");
    cyc(0, 1, 8'h28, 32'h81, "R7");
    // R9: near-miss values at the reset register
    cyc(0, 1, 8'h40, 32'h0B, "R9");
    cyc(0, 1, 8'h40, 32'h1000_000A, "R9");
    cyc(0, 0, 8'h20, 0, "R9"); cyc(0, 0, 8'h28, 0, "R9");
    // R10: unmapped reads
    cyc(0, 0, 8'h24, 0, "R10"); cyc(0, 0, 8'h40, 0, "R10");
    // R8: key write with a simultaneous event, then one-cycle pulse
    cyc(8'hFF, 1, 8'h40, 32'hA, "R8");
    cyc(0, 0, 8'h20, 0, "R8");
    cyc(0, 0, 8'h28, 0, "R8");
    cyc(0, 0, 8'h1C, 0, "R8");

    // random mix over all requirements (R2 R3 R5 R6 R7 R8 R9)
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  ev, a;
      logic        we;
      logic [31:0] d;
      ev = 8'($urandom & $urandom & $urandom);
      we = ($urandom % 3) == 0;
      a  = addrs[$urandom % 6];
      d  = $urandom;
      if (a == 8'h40 && ($urandom % 4) == 0) d = 32'hA;
      if (a == 8'h1C && ($urandom % 2) == 0) d[31] = 1'b1;
      cyc(ev, we, a, d, "RND");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule